// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a translation lookaside buffer with 64 entries. Instruction fetches and data accesses use the same buffer. Each entry describes one page. The page size is chosen per entry from eight sizes, 1 KiB to 16 MiB, rising by a factor of four per step. The number of effective-address bits compared against an entry therefore depends on that entry's size code.

Software owns the contents completely. A plain command port writes the tag word or data word of an indexed entry and reads an entry back. The same port searches the buffer for an address and invalidates either every entry or all entries that match an address. The hardware never refills, replaces or walks tables on its own.

Lookups come in as a valid/ready stream and leave as a valid/ready stream with one output register.
- An effective address is accepted when `lk_valid` and `lk_ready` are both high.
- `lk_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A result stays on the output, unchanged, until `res_ready` takes it.
- Each result gives hit or miss, the hit index, the real address, the execute and write permissions, the zone number and the four cache attributes.

Top module: `vpt_tlb`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, every search reports not found, and `res_valid` and `rsp_valid` are low.
- R2: Tag and data layout, read back through the read command:
  - Tag word: bits 31:10 are the effective page number, bits 9:7 are the size code, bit 6 is the valid flag. Bits 5:0 always read as zero.
  - Data word: all 32 bits are stored and returned. Bits 31:10 are the real page number, bit 9 is execute-allowed, bit 8 is write-allowed, bits 7:4 are the zone, and bits 3:0 are the write-through, inhibit, coherent and guarded attributes, from high to low.
- R3: A valid entry with size code s matches an effective address when the address bits 31:(10+2s) equal the same bits of the entry's page number. Code 0 is 1 KiB and compares bits 31:10; code 7 is 16 MiB and compares bits 31:24.
- R4: On a hit, the real address takes the real page number in the compared bit positions. The remaining low bits are copied from the effective address.
- R5: On a hit, `res_ex`, `res_wr`, `res_zone`, `res_attr` and `res_idx` come from the winning entry. On a miss, `res_hit` and all of those outputs, plus `res_ra`, are zero.
- R6: The invalidate-all command (`cmd_op`=5) clears the valid flag of every entry.
- R7: The invalidate-one command (`cmd_op`=4, address on `cmd_wdata`) clears the valid flag of every entry that matches the address under R3. All other entries keep their flags.
- R8: When several valid entries match, the lowest-numbered entry wins, both for lookups and for searches.
- R9: Read (`cmd_op`=2) and search (`cmd_op`=3) raise `rsp_valid` for exactly one cycle, in the cycle after the command.
  - Search takes its address on `cmd_wdata` and returns the found flag and the winner's index. `rsp_tag` and `rsp_data` hold the words of that entry.
  - Read returns the words of entry `cmd_idx`, with `rsp_found` equal to that entry's valid flag.
  - Command codes: write tag (`cmd_op`=0) and write data (`cmd_op`=1) store `cmd_wdata` into entry `cmd_idx`. Codes 6 and 7 do nothing.
- R10: A result appears on `res_*` in the cycle after its address is accepted. While `res_valid` is high and `res_ready` is low:
  - `lk_ready` is low;
  - the result holds stable.
- R11: A command changes the table at the end of its cycle. A lookup accepted in the same cycle as a write or invalidate sees the old contents, and a lookup in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup address can be accepted |
| lk_ea | input | 32 | Effective address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Address matched a valid entry |
| res_idx | output | 6 | Winning entry index |
| res_ra | output | 32 | Translated real address |
| res_ex | output | 1 | Execute allowed |
| res_wr | output | 1 | Write allowed |
| res_zone | output | 4 | Zone number |
| res_attr | output | 4 | Write-through, inhibit, coherent, guarded |
| cmd_valid | input | 1 | Maintenance command strobe |
| cmd_op | input | 3 | Command code |
| cmd_idx | input | 6 | Entry index for write and read |
| cmd_wdata | input | 32 | Write word, or address for search and invalidate-one |
| rsp_valid | output | 1 | Read or search response valid |
| rsp_found | output | 1 | Search found an entry, or the read entry is valid |
| rsp_idx | output | 6 | Index of the reported entry |
| rsp_tag | output | 32 | Tag word of the reported entry |
| rsp_data | output | 32 | Data word of the reported entry |

## Verification
The hardest case to reach from the ports is an address that falls inside two valid entries of different page sizes. The stimulus sets this up by placing a 256 KiB page at a high index inside the span of a 16 MiB page at index 0. Lookups, searches and invalidate-one then all hit the overlap. A second hard case is a lookup that races a table change: the bench issues invalidate-all in the same cycle as an accepted lookup that must still hit, then looks up the same address again. Back-pressure is covered by holding `res_ready` low while a second address waits on the input.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

  localparam int WORD_W   = 32;
  localparam int PN_LSB   = 10;
  localparam int PN_W     = WORD_W - PN_LSB;
  localparam int SIZE_W   = 3;

  typedef enum logic [2:0] {
    OP_WTAG   = 3'd0,
    OP_WDATA  = 3'd1,
    OP_READ   = 3'd2,
    OP_SEARCH = 3'd3,
    OP_INV1   = 3'd4,
    OP_INVALL = 3'd5
  } tlb_op_e;

  // Bits kept (1) for a page of the given size code: above the page offset.
  function automatic logic [WORD_W-1:0] page_mask(input logic [SIZE_W-1:0] s);
    page_mask = {WORD_W{1'b1}} << (PN_LSB + 2 * int'(s));
  endfunction

endpackage

// File: rtl/vpt_store.sv
module vpt_store
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDXW = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we_tag,
  input  logic                           we_data,
  input  logic [IDXW-1:0]                widx,
  input  logic [WORD_W-1:0]              wdata,
  input  logic                           inv_all,
  input  logic [ENTRIES-1:0]             inv_vec,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [ENTRIES-1:0][PN_W-1:0]   epn_o,
  output logic [ENTRIES-1:0][SIZE_W-1:0] size_o,
  output logic [ENTRIES-1:0][WORD_W-1:0] data_o
);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][PN_W-1:0]   epn_q;
  logic [ENTRIES-1:0][SIZE_W-1:0] size_q;
  logic [ENTRIES-1:0][WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      epn_q   <= '0;
      size_q  <= '0;
      data_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_all || inv_vec[i]) begin
          valid_q[i] <= 1'b0;
        end else if (we_tag && widx == IDXW'(i)) begin
          valid_q[i] <= wdata[PN_LSB-SIZE_W-1];
        end
        if (we_tag && widx == IDXW'(i)) begin
          epn_q[i]  <= wdata[WORD_W-1:PN_LSB];
          size_q[i] <= wdata[PN_LSB-1:PN_LSB-SIZE_W];
        end
        if (we_data && widx == IDXW'(i)) begin
          data_q[i] <= wdata;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign epn_o   = epn_q;
  assign size_o  = size_q;
  assign data_o  = data_q;

  AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0)); // R6
  AST_INV_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_vec != '0) |=> ((valid_q & $past(inv_vec)) == '0)); // R7

endmodule

// File: rtl/vpt_match.sv
module vpt_match
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [WORD_W-1:0]              addr,
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][PN_W-1:0]   epn,
  input  logic [ENTRIES-1:0][SIZE_W-1:0] size,
  output logic [ENTRIES-1:0]             hit_vec
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [WORD_W-1:0] diff;
    assign diff       = (addr ^ {epn[g], {PN_LSB{1'b0}}}) & page_mask(size[g]);
    assign hit_vec[g] = valid[g] && (diff == '0);
  end

endmodule

// File: rtl/vpt_prio.sv
module vpt_prio #(
  parameter int ENTRIES = 64,
  localparam int IDXW = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               found,
  output logic [IDXW-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDXW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [31:0]       lk_ea,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [IDXW-1:0]   res_idx,
  output logic [31:0]       res_ra,
  output logic              res_ex,
  output logic              res_wr,
  output logic [3:0]        res_zone,
  output logic [3:0]        res_attr,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDXW-1:0]   cmd_idx,
  input  logic [31:0]       cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_found,
  output logic [IDXW-1:0]   rsp_idx,
  output logic [31:0]       rsp_tag,
  output logic [31:0]       rsp_data
);

  localparam int EX_BIT   = 9;
  localparam int WR_BIT   = 8;
  localparam int ZONE_LSB = 4;

  logic [ENTRIES-1:0]             valid;
  logic [ENTRIES-1:0][PN_W-1:0]   epn;
  logic [ENTRIES-1:0][SIZE_W-1:0] size;
  logic [ENTRIES-1:0][WORD_W-1:0] data;

  logic is_wtag, is_wdata, is_read, is_search, is_inv1, is_invall;
  always_comb begin
    is_wtag   = cmd_valid && cmd_op == OP_WTAG;
    is_wdata  = cmd_valid && cmd_op == OP_WDATA;
    is_read   = cmd_valid && cmd_op == OP_READ;
    is_search = cmd_valid && cmd_op == OP_SEARCH;
    is_inv1   = cmd_valid && cmd_op == OP_INV1;
    is_invall = cmd_valid && cmd_op == OP_INVALL;
  end

  // Command-side match (search and invalidate-one share it)
  logic [ENTRIES-1:0] cmd_hits;
  logic               cmd_found;
  logic [IDXW-1:0]    cmd_win;

  vpt_match #(.ENTRIES(ENTRIES)) u_cmd_match (
    .addr(cmd_wdata), .valid(valid), .epn(epn), .size(size), .hit_vec(cmd_hits)
  );
  vpt_prio #(.ENTRIES(ENTRIES)) u_cmd_prio (
    .req(cmd_hits), .found(cmd_found), .idx(cmd_win)
  );

  vpt_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_tag(is_wtag), .we_data(is_wdata), .widx(cmd_idx), .wdata(cmd_wdata),
    .inv_all(is_invall), .inv_vec(is_inv1 ? cmd_hits : '0),
    .valid_o(valid), .epn_o(epn), .size_o(size), .data_o(data)
  );

  // Lookup-side match
  logic [ENTRIES-1:0] lk_hits;
  logic               lk_found;
  logic [IDXW-1:0]    lk_win;

  vpt_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .addr(lk_ea), .valid(valid), .epn(epn), .size(size), .hit_vec(lk_hits)
  );
  vpt_prio #(.ENTRIES(ENTRIES)) u_lk_prio (
    .req(lk_hits), .found(lk_found), .idx(lk_win)
  );

  logic [WORD_W-1:0] win_mask, win_data, ra_next;
  always_comb begin
    win_mask = page_mask(size[lk_win]);
    win_data = data[lk_win];
    ra_next  = (win_data & win_mask) | (lk_ea & ~win_mask);
  end

  logic accept;
  assign lk_ready = !res_valid || res_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_ra    <= '0;
      res_ex    <= 1'b0;
      res_wr    <= 1'b0;
      res_zone  <= '0;
      res_attr  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_hit   <= lk_found;
      res_idx   <= lk_found ? lk_win : '0;
      res_ra    <= lk_found ? ra_next : '0;
      res_ex    <= lk_found && win_data[EX_BIT];
      res_wr    <= lk_found && win_data[WR_BIT];
      res_zone  <= lk_found ? win_data[ZONE_LSB+3:ZONE_LSB] : '0;
      res_attr  <= lk_found ? win_data[3:0] : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // Response to read and search
  logic [IDXW-1:0] pick;
  assign pick = is_search ? cmd_win : cmd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_idx   <= '0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= is_read || is_search;
      if (is_read || is_search) begin
        rsp_found <= is_search ? cmd_found : valid[cmd_idx];
        rsp_idx   <= pick;
        rsp_tag   <= {epn[pick], size[pick], valid[pick], 6'b0};
        rsp_data  <= data[pick];
      end
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_ra) && $stable(res_idx) && $stable(res_hit))); // R10
  AST_RSP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read || is_search) |=> rsp_valid); // R9
  AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid)); // R9
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (!res_ex && !res_wr && res_ra == '0)); // R5

endmodule

// File: tb/vpt_tlb_bench.sv
module vpt_tlb_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_ready, res_valid, res_ready = 1'b1;
  logic [31:0] lk_ea = '0;
  logic        res_hit, res_ex, res_wr;
  logic [5:0]  res_idx;
  logic [31:0] res_ra;
  logic [3:0]  res_zone, res_attr;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid, rsp_found;
  logic [5:0]  rsp_idx;
  logic [31:0] rsp_tag, rsp_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vpt_tlb u_vpt_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_ea(lk_ea),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_idx(res_idx), .res_ra(res_ra), .res_ex(res_ex), .res_wr(res_wr),
    .res_zone(res_zone), .res_attr(res_attr),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_idx(rsp_idx),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  typedef struct packed {
    logic [31:0] ea;
    logic        hit;
    logic [5:0]  idx;
    logic [31:0] ra;
    logic        ex;
    logic        wr;
    logic [3:0]  zone;
    logic [3:0]  attr;
  } vec_t;

  // R3 R4 R5 R8 lookup vectors against the table built below
  localparam vec_t TBL [9] = '{
    '{32'h10FFFFFF, 1'b1, 6'd0,  32'h80FFFFFF, 1'b1, 1'b0, 4'd3,  4'hA},
    '{32'h11000000, 1'b0, 6'd0,  32'h00000000, 1'b0, 1'b0, 4'd0,  4'h0},
    '{32'h200007FF, 1'b1, 6'd5,  32'h00ABC3FF, 1'b0, 1'b1, 4'd15, 4'h5},
    '{32'h20000800, 1'b0, 6'd0,  32'h00000000, 1'b0, 1'b0, 4'd0,  4'h0},
    '{32'h3001ABCD, 1'b1, 6'd9,  32'h4567ABCD, 1'b1, 1'b1, 4'd1,  4'h0},
    '{32'h30020000, 1'b0, 6'd0,  32'h00000000, 1'b0, 1'b0, 4'd0,  4'h0},
    '{32'h40000FFF, 1'b1, 6'd63, 32'h7FFFFFFF, 1'b1, 1'b1, 4'd12, 4'hF},
    '{32'h40001000, 1'b0, 6'd0,  32'h00000000, 1'b0, 1'b0, 4'd0,  4'h0},
    '{32'h10412345, 1'b1, 6'd0,  32'h80412345, 1'b1, 1'b0, 4'd3,  4'hA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [5:0] idx, input logic [31:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] ea);
    @(negedge clk);
    lk_valid = 1'b1; lk_ea = ea;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic check_res(input string req, input vec_t v);
    chk(req, {31'b0, res_valid}, 32'd1);
    chk(req, {31'b0, res_hit}, {31'b0, v.hit});
    chk(req, {26'b0, res_idx}, {26'b0, v.idx});
    chk(req, res_ra, v.ra);
    chk(req, {22'b0, res_ex, res_wr, res_zone, res_attr}, {22'b0, v.ex, v.wr, v.zone, v.attr});
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    lookup(32'h00000000);
    check_res("R1 lookup", '{32'h0, 1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 4'd0, 4'h0});
    cmd(3'd2, 6'd0, 32'h0);
    chk("R1 read valid", {31'b0, rsp_found}, 32'd0);

    // Build table
    cmd(3'd0, 6'd0,  32'h100003C0); cmd(3'd1, 6'd0,  32'h8000023A);
    cmd(3'd0, 6'd5,  32'h20000440); cmd(3'd1, 6'd5,  32'h00ABC1F5);
    cmd(3'd0, 6'd9,  32'h300101C0); cmd(3'd1, 6'd9,  32'h45670310);
    cmd(3'd0, 6'd12, 32'h10400240); cmd(3'd1, 6'd12, 32'h0C000121);
    cmd(3'd0, 6'd63, 32'h400000C0); cmd(3'd1, 6'd63, 32'h7FFFF3CF);

    for (int k = 0; k < 9; k++) begin
      lookup(TBL[k].ea);
      check_res("R3/R4/R5/R8 table", TBL[k]);
    end

    // R2 readback
    cmd(3'd2, 6'd12, 32'h0);
    chk("R2 tag", rsp_tag, 32'h10400240);
    chk("R2 data", rsp_data, 32'h0C000121);
    cmd(3'd0, 6'd20, 32'h5000007F);
    cmd(3'd2, 6'd20, 32'h0);
    chk("R2 low tag bits zero", rsp_tag, 32'h50000040);
    chk("R2 found valid", {31'b0, rsp_found}, 32'd1);

    // R9 search, R8 lowest wins
    cmd(3'd3, 6'd0, 32'h10412345);
    chk("R9 search found", {31'b0, rsp_found}, 32'd1);
    chk("R8 search idx", {26'b0, rsp_idx}, 32'd0);
    chk("R9 search data", rsp_data, 32'h8000023A);
    @(negedge clk);
    chk("R9 rsp pulse", {31'b0, rsp_valid}, 32'd0);
    cmd(3'd3, 6'd0, 32'h3001FFFF);
    chk("R9 search idx9", {26'b0, rsp_idx}, 32'd9);
    cmd(3'd3, 6'd0, 32'h99000000);
    chk("R9 search miss", {31'b0, rsp_found}, 32'd0);
    cmd(3'd6, 6'd5, 32'h0);
    lookup(32'h200007FF);
    chk("R9 unused op no effect", {31'b0, res_hit}, 32'd1);

    // R10 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    lk_valid = 1'b1; lk_ea = 32'h200007FF;
    @(negedge clk);
    lk_ea = 32'h3001ABCD;
    chk("R10 lk_ready low", {31'b0, lk_ready}, 32'd0);
    @(negedge clk);
    chk("R10 held ra", res_ra, 32'h00ABC3FF);
    chk("R10 held idx", {26'b0, res_idx}, 32'd5);
    res_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R10 next result", res_ra, 32'h4567ABCD);

    // R7 invalidate-one clears both overlapping entries
    cmd(3'd4, 6'd0, 32'h10412345);
    lookup(32'h10412345);
    chk("R7 overlap gone", {31'b0, res_hit}, 32'd0);
    cmd(3'd3, 6'd0, 32'h10412345);
    chk("R7 search gone", {31'b0, rsp_found}, 32'd0);
    lookup(32'h200007FF);
    chk("R7 other kept", {26'b0, res_idx, res_hit}, {26'b0, 6'd5, 1'b1});

    // R11 lookup racing invalidate-all sees old table
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd5;
    lk_valid = 1'b1; lk_ea = 32'h3001ABCD;
    @(negedge clk);
    cmd_valid = 1'b0; lk_valid = 1'b0;
    chk("R11 old contents", {31'b0, res_hit}, 32'd1);
    lookup(32'h3001ABCD);
    chk("R6 cleared 9", {31'b0, res_hit}, 32'd0);
    lookup(32'h40000FFF);
    chk("R6 cleared 63", {31'b0, res_hit}, 32'd0);
    cmd(3'd2, 6'd20, 32'h0);
    chk("R6 read valid", {31'b0, rsp_found}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule